// File: doc/BRIEF.md
# Fabric Link Bring-Up Sequencer

This block brings up one end of a full-duplex switch fabric link. Two cooperating devices share the link, and a serial sideband carries a pair of ready bits (control-ready and data-ready) between them. Out of reset the block forces the ready bits it sends to zero. It enables the transmitter in an Idle-only mode and waits for the receiver to report the first Idle frame. It then releases its override and announces readiness to the peer.

Once the peer's ready bits arrive over the sideband, the block qualifies them through a synchronizer and a run of consecutive sideband frames. Only then does it enable control-frame and data-frame transmission. The synchronized peer ready bits are also handed to the framer for the base header of outgoing frames. Software may rewrite the force override or the ready-bit field at any time, and a write overrides the automatic sequence in the same cycle.

All pins are plain control and status levels or single-cycle strobes. The block has no streaming interface and applies no back-pressure.

Top module: `fabric_link_seq`

## Requirements
- R1: While `rst_n` is low, `ovr_force` is 1, `sb_rdy_out` is 00, `tx_en`, `tx_en_ctl`, `tx_en_dat`, `idle_seen` and `irq` are 0, and `state_o` is 0.
- R2: One clock after reset is released, the state is 1 (waiting for Idle), with `tx_en` = 1, `tx_idle_only` = 1 and `sb_rdy_out` still 00.
- R3: An `idle_det` pulse while `rx_en` is 0 has no effect: `idle_seen` stays 0 and the state stays 1.
- R4: An `idle_det` pulse while `rx_en` is 1 sets `idle_seen` on the next clock, and it then stays set until reset. `irq` equals `idle_seen` AND `irq_en`.
- R5: The state goes to 2 (release) one clock after `idle_seen` rises. On the following clock the block clears `ovr_force`, writes 11 into the ready field, and enters state 3 (waiting for peer). With no software write, `sb_rdy_out` then reads 11.
- R6: `sb_rdy_out` is 00 whenever `ovr_force` is 1, and is the ready field otherwise. `hdr_rdy` is 00 whenever `ovr_force` is 1, and is otherwise `sb_rdy_in` delayed through a two-flop synchronizer. Bit 1 is control-ready and bit 0 is data-ready.
- R7: In state 3, every `sb_frame` strobe with synchronized ready bits equal to 11 adds one to a run count. A strobe with any other value clears the count, and clock cycles without a strobe leave it unchanged. The state becomes 4 one clock after the count reaches QUAL_FRAMES (default 2).
- R8: In state 4, `tx_en_ctl` = `tx_en_dat` = 1 and `tx_idle_only` = 0. Both enables are 0 in every other state.
- R9: A `sw_wr_force` strobe loads `sw_force_val` into `ovr_force`, and a `sw_wr_rdy` strobe loads `sw_rdy_val` into the ready field. Each write takes effect on the next clock and wins over the automatic release in the same cycle.
- R10: `state_o` encodes the states as 0 reset-force, 1 wait-idle, 2 release, 3 wait-peer and 4 normal. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable for Idle detection |
| idle_det | input | 1 | Receiver strobe: an Idle frame was received |
| irq_en | input | 1 | Interrupt enable for the Idle-seen flag |
| sb_rdy_in | input | 2 | Ready bits received on the sideband (asynchronous) |
| sb_frame | input | 1 | Strobe marking the end of a received sideband frame |
| sw_wr_force | input | 1 | Software write strobe for the force override |
| sw_force_val | input | 1 | Value written to the force override |
| sw_wr_rdy | input | 1 | Software write strobe for the ready field |
| sw_rdy_val | input | 2 | Value written to the ready field |
| sb_rdy_out | output | 2 | Ready bits sent on the sideband |
| hdr_rdy | output | 2 | Peer ready bits for the outgoing base header |
| ovr_force | output | 1 | Current force override |
| tx_en | output | 1 | Transmitter enable |
| tx_idle_only | output | 1 | Transmitter restricted to Idle frames |
| tx_en_ctl | output | 1 | Control-frame transmit enable |
| tx_en_dat | output | 1 | Data-frame transmit enable |
| idle_seen | output | 1 | Sticky flag: first Idle frame detected |
| irq | output | 1 | Interrupt request |
| state_o | output | 3 | Current sequencer state |

## Verification
The assertions assume that reset is held for at least one clock. The synchronizer check also assumes that `sb_rdy_in` is sampled only after reset is released, because its two-cycle history is taken from that point on. The software-write properties assume that a ready-field write is judged only while no force write is made in the same cycle. The stimulus drives every input on the falling edge and holds it across at least one rising edge. It changes `sb_rdy_in` at least three cycles before any `sb_frame` strobe, so every strobe sees a settled synchronized value.

// File: rtl/fls_pkg.sv
package fls_pkg;
  typedef enum logic [2:0] {
    ST_RESET_FORCE = 3'd0,
    ST_WAIT_IDLE   = 3'd1,
    ST_RELEASE     = 3'd2,
    ST_WAIT_PEER   = 3'd3,
    ST_NORMAL      = 3'd4
  } link_st_e;

  localparam int RDY_W = 2;
  localparam logic [RDY_W-1:0] RDY_ALL = '1;
  localparam logic [RDY_W-1:0] RDY_NONE = '0;
endpackage

// File: rtl/fls_sync.sv
module fls_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stg[gi] <= '0;
          else        stg[gi] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) stg[gi] <= '0;
          else        stg[gi] <= stg[gi-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fls_qual.sv
module fls_qual #(
  parameter int QUAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic frame,
  input  logic both_rdy,
  output logic done
);
  localparam int CW = $clog2(QUAL + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL);

  logic [CW-1:0] run_cnt;

  assign done = (run_cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n || !arm) begin
      run_cnt <= '0;
    end else if (frame && !done) begin
      if (both_rdy) run_cnt <= run_cnt + 1'b1;
      else          run_cnt <= '0;
    end
  end
endmodule

// File: rtl/fls_ctl_regs.sv
module fls_ctl_regs
  import fls_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_release,
  input  logic             sw_wr_force,
  input  logic             sw_force_val,
  input  logic             sw_wr_rdy,
  input  logic [RDY_W-1:0] sw_rdy_val,
  output logic             force_q,
  output logic [RDY_W-1:0] field_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_q <= 1'b1;
    end else if (sw_wr_force) begin
      force_q <= sw_force_val;
    end else if (auto_release) begin
      force_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_q <= RDY_NONE;
    end else if (sw_wr_rdy) begin
      field_q <= sw_rdy_val;
    end else if (auto_release) begin
      field_q <= RDY_ALL;
    end
  end
endmodule

// File: rtl/fls_fsm.sv
module fls_fsm
  import fls_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rx_en,
  input  logic     idle_det,
  input  logic     qual_done,
  output logic     idle_seen,
  output link_st_e state,
  output logic     auto_release,
  output logic     arm_qual
);
  link_st_e nxt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 idle_seen <= 1'b0;
    else if (rx_en && idle_det) idle_seen <= 1'b1;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RESET_FORCE: nxt = ST_WAIT_IDLE;
      ST_WAIT_IDLE:   if (idle_seen) nxt = ST_RELEASE;
      ST_RELEASE:     nxt = ST_WAIT_PEER;
      ST_WAIT_PEER:   if (qual_done) nxt = ST_NORMAL;
      ST_NORMAL:      nxt = ST_NORMAL;
      default:        nxt = ST_RESET_FORCE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_RESET_FORCE;
    else        state <= nxt;
  end

  assign auto_release = (state == ST_RELEASE);
  assign arm_qual     = (state == ST_WAIT_PEER);
endmodule

// File: rtl/fabric_link_seq.sv
module fabric_link_seq
  import fls_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       idle_det,
  input  logic       irq_en,
  input  logic [1:0] sb_rdy_in,
  input  logic       sb_frame,
  input  logic       sw_wr_force,
  input  logic       sw_force_val,
  input  logic       sw_wr_rdy,
  input  logic [1:0] sw_rdy_val,
  output logic [1:0] sb_rdy_out,
  output logic [1:0] hdr_rdy,
  output logic       ovr_force,
  output logic       tx_en,
  output logic       tx_idle_only,
  output logic       tx_en_ctl,
  output logic       tx_en_dat,
  output logic       idle_seen,
  output logic       irq,
  output logic [2:0] state_o
);
  logic [RDY_W-1:0] peer_rdy;
  logic [RDY_W-1:0] field_q;
  logic             force_q;
  logic             qual_done;
  logic             auto_release;
  logic             arm_qual;
  logic             seen_q;
  link_st_e         st;

  fls_sync #(.W(RDY_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sb_rdy_in), .q(peer_rdy)
  );

  fls_qual #(.QUAL(QUAL_FRAMES)) u_qual (
    .clk(clk), .rst_n(rst_n), .arm(arm_qual), .frame(sb_frame),
    .both_rdy(peer_rdy == RDY_ALL), .done(qual_done)
  );

  fls_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .auto_release(auto_release),
    .sw_wr_force(sw_wr_force), .sw_force_val(sw_force_val),
    .sw_wr_rdy(sw_wr_rdy), .sw_rdy_val(sw_rdy_val),
    .force_q(force_q), .field_q(field_q)
  );

  fls_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .idle_det(idle_det),
    .qual_done(qual_done), .idle_seen(seen_q), .state(st),
    .auto_release(auto_release), .arm_qual(arm_qual)
  );

  assign ovr_force    = force_q;
  assign sb_rdy_out   = force_q ? RDY_NONE : field_q;
  assign hdr_rdy      = force_q ? RDY_NONE : peer_rdy;
  assign tx_en        = (st != ST_RESET_FORCE);
  assign tx_idle_only = (st != ST_NORMAL);
  assign tx_en_ctl    = (st == ST_NORMAL);
  assign tx_en_dat    = (st == ST_NORMAL);
  assign idle_seen    = seen_q;
  assign irq          = seen_q && irq_en;
  assign state_o      = st;
endmodule

// File: rtl/fls_checker.sv
module fls_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       idle_det,
  input logic [1:0] sb_rdy_in,
  input logic       sw_wr_force,
  input logic       sw_force_val,
  input logic       sw_wr_rdy,
  input logic [1:0] sw_rdy_val,
  input logic [1:0] sb_rdy_out,
  input logic [1:0] hdr_rdy,
  input logic       ovr_force,
  input logic       tx_en,
  input logic       tx_idle_only,
  input logic       tx_en_ctl,
  input logic       tx_en_dat,
  input logic       idle_seen,
  input logic [2:0] state_o
);
  AST_WAIT_IDLE_TX: assert property (@(posedge clk) disable iff (!rst_n) (state_o == 3'd1) |-> (tx_en && tx_idle_only)); // R2
  AST_IGNORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!rx_en && !idle_seen) |=> !idle_seen); // R3
  AST_IDLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) idle_seen |=> idle_seen); // R4
  AST_IDLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (rx_en && idle_det) |=> idle_seen); // R4
  AST_HDR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n) (!ovr_force && !$past(ovr_force) && state_o != 3'd1) |-> (hdr_rdy == $past(sb_rdy_in, 2))); // R6
  AST_ENABLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_en_ctl) |-> ($past(state_o) == 3'd3)); // R7
  AST_NORMAL_MODE: assert property (@(posedge clk) disable iff (!rst_n) (tx_en_ctl || tx_en_dat) |-> (tx_en && !tx_idle_only)); // R8
  AST_SW_FORCE: assert property (@(posedge clk) disable iff (!rst_n) sw_wr_force |=> (ovr_force == $past(sw_force_val))); // R9
  AST_SW_FIELD: assert property (@(posedge clk) disable iff (!rst_n) (sw_wr_rdy && !sw_wr_force && !ovr_force) |=> (sb_rdy_out == $past(sw_rdy_val))); // R9
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) state_o <= 3'd4); // R10
endmodule

bind fabric_link_seq fls_checker u_fls_checker (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .idle_det(idle_det),
  .sb_rdy_in(sb_rdy_in), .sw_wr_force(sw_wr_force), .sw_force_val(sw_force_val),
  .sw_wr_rdy(sw_wr_rdy), .sw_rdy_val(sw_rdy_val), .sb_rdy_out(sb_rdy_out),
  .hdr_rdy(hdr_rdy), .ovr_force(ovr_force), .tx_en(tx_en),
  .tx_idle_only(tx_idle_only), .tx_en_ctl(tx_en_ctl), .tx_en_dat(tx_en_dat),
  .idle_seen(idle_seen), .state_o(state_o)
);

// File: tb/test_fabric_link_seq.sv
module test_fabric_link_seq;
  localparam int QUAL = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_en, idle_det, irq_en, sb_frame;
  logic [1:0] sb_rdy_in;
  logic       sw_wr_force, sw_force_val, sw_wr_rdy;
  logic [1:0] sw_rdy_val;
  logic [1:0] sb_rdy_out, hdr_rdy;
  logic       ovr_force, tx_en, tx_idle_only, tx_en_ctl, tx_en_dat, idle_seen, irq;
  logic [2:0] state_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fabric_link_seq #(.SYNC_STAGES(2), .QUAL_FRAMES(QUAL)) i_fabric_link_seq (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .idle_det(idle_det), .irq_en(irq_en),
    .sb_rdy_in(sb_rdy_in), .sb_frame(sb_frame), .sw_wr_force(sw_wr_force),
    .sw_force_val(sw_force_val), .sw_wr_rdy(sw_wr_rdy), .sw_rdy_val(sw_rdy_val),
    .sb_rdy_out(sb_rdy_out), .hdr_rdy(hdr_rdy), .ovr_force(ovr_force), .tx_en(tx_en),
    .tx_idle_only(tx_idle_only), .tx_en_ctl(tx_en_ctl), .tx_en_dat(tx_en_dat),
    .idle_seen(idle_seen), .irq(irq), .state_o(state_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_en = 1'b0; idle_det = 1'b0; irq_en = 1'b0; sb_frame = 1'b0;
    sb_rdy_in = 2'b00; sw_wr_force = 1'b0; sw_force_val = 1'b0;
    sw_wr_rdy = 1'b0; sw_rdy_val = 2'b00;
    tick(3);
    chk_eq("R1 state", state_o, 0);
    chk_eq("R1 force", ovr_force, 1);
    chk_eq("R1 sb_rdy_out", sb_rdy_out, 0);
    chk_eq("R1 enables", {tx_en, tx_en_ctl, tx_en_dat}, 0);
    chk_eq("R1 idle_seen/irq", {idle_seen, irq}, 0);
    rst_n = 1'b1;
    tick(1);
    chk_eq("R2 state", state_o, 1);
    chk_eq("R2 tx_en/idle_only", {tx_en, tx_idle_only}, 3);
    chk_eq("R2 sb_rdy_out", sb_rdy_out, 0);
  endtask

  task automatic sw_field(input logic [1:0] v);
    sw_wr_rdy = 1'b1; sw_rdy_val = v; tick(1); sw_wr_rdy = 1'b0;
  endtask

  task automatic sw_force(input logic v);
    sw_wr_force = 1'b1; sw_force_val = v; tick(1); sw_wr_force = 1'b0;
  endtask

  function automatic logic [1:0] pat(input int i);
    case (i)
      0: pat = 2'b11;
      1: pat = 2'b00;
      2: pat = 2'b01;
      3: pat = 2'b10;
      default: pat = 2'b11;
    endcase
  endfunction

  initial begin
    int run;
    // Phase 1: override behaviour and software precedence
    do_reset();
    sb_rdy_in = 2'b11; tick(4);
    chk_eq("R6 hdr forced low", hdr_rdy, 0);
    rx_en = 1'b0; idle_det = 1'b1; tick(1); idle_det = 1'b0; tick(2);
    chk_eq("R3 idle ignored", idle_seen, 0);
    chk_eq("R3 state held", state_o, 1);
    sw_field(2'b11);
    chk_eq("R6 field masked by force", sb_rdy_out, 0);
    sw_force(1'b0);
    chk_eq("R9 force cleared by write", ovr_force, 0);
    chk_eq("R6 hdr mirrors sync", hdr_rdy, 3);
    for (int v = 0; v < 4; v++) begin
      sw_field(v[1:0]);
      chk_eq("R9 field write", sb_rdy_out, v);
    end
    sw_force(1'b1);
    sw_field(2'b00);
    chk_eq("R9 force set by write", {ovr_force, sb_rdy_out}, 4);
    rx_en = 1'b1; irq_en = 1'b1; idle_det = 1'b1; tick(1); idle_det = 1'b0;
    chk_eq("R4 idle_seen", idle_seen, 1);
    chk_eq("R4 irq", irq, 1);
    chk_eq("R4 state before release", state_o, 1);
    tick(1);
    chk_eq("R5 release state", state_o, 2);
    sw_field(2'b01);
    chk_eq("R5 wait-peer state", state_o, 3);
    chk_eq("R5 auto force clear", ovr_force, 0);
    chk_eq("R9 write beats auto field", sb_rdy_out, 1);
    irq_en = 1'b0; #1;
    chk_eq("R4 irq masked", irq, 0);
    chk_eq("R4 sticky", idle_seen, 1);

    // Phase 2: pure automatic sequence and peer qualification
    do_reset();
    rx_en = 1'b1; idle_det = 1'b1; tick(1); idle_det = 1'b0; tick(2);
    chk_eq("R5 auto sb_rdy_out", sb_rdy_out, 3);
    chk_eq("R5 state", state_o, 3);
    chk_eq("R10 wait-peer code", state_o, 3);
    run = 0;
    for (int i = 0; i < 6; i++) begin
      logic [1:0] v;
      v = pat(i);
      sb_rdy_in = v; tick(3);
      chk_eq("R6 hdr sweep", hdr_rdy, v);
      chk_eq("R7 no enable before run", {tx_en_ctl, tx_en_dat}, 0);
      sb_frame = 1'b1; tick(1); sb_frame = 1'b0;
      run = (v == 2'b11) ? run + 1 : 0;
      chk_eq("R7 held in wait-peer", state_o, 3);
      if (run >= QUAL) begin
        tick(1);
        chk_eq("R7 normal after run", state_o, 4);
        chk_eq("R8 enables", {tx_en_ctl, tx_en_dat}, 3);
        chk_eq("R8 idle-only off", tx_idle_only, 0);
        chk_eq("R10 normal code", state_o, 4);
      end
    end
    chk_eq("R7 run reached", run, QUAL);
    sb_rdy_in = 2'b00; tick(4);
    sb_frame = 1'b1; tick(1); sb_frame = 1'b0; tick(1);
    chk_eq("R8 normal is terminal", {state_o, tx_en_ctl}, 9);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule